// File: doc/BRIEF.md
# Shared-Bus SPI Command Sequencer for a Gain Amplifier with Input Multiplexer

This block is the host side of a serial link to a programmable-gain amplifier that has an input multiplexer. The amplifier sits on an SPI bus that other devices also use. A client hands the block one request at a time through a valid/ready pair. The request is one of five operations: pick an input channel and gain, read back the configuration, do nothing, power down, or wake up. The block requests the bus from an external arbiter and waits for the grant. It then spends one full serial clock period driving the bus at its own idle levels, which restores its clock mode and rate. After that it sends the frames the operation needs and gives the bus back.

Words are 16 bits long. They go out most significant bit first in SPI mode 0: the clock idles low, the device samples on the rising edge, and data changes on the falling edge. A read uses two chip-select windows. The first carries the read command. The second clocks out all-ones filler while the reply is captured. The chip select stays high for at least one serial clock period between the two windows. When the `CHAIN` parameter is set, two devices are daisy-chained. Each window then carries 32 bits: the command word, then the same word with bit 15 set. A read in this mode returns 32 bits. `HALF_DIV` sets the number of system clocks in each half of the serial clock. With a 100 MHz system clock, the default of 50 gives a 1 MHz serial clock.

The sequencer moves through seven states:
- IDLE goes to ACQUIRE when a request is accepted.
- ACQUIRE goes to SETUP when the grant arrives.
- SETUP goes to CMD after 2·HALF_DIV cycles.
- CMD goes to GAP when its frame ends on a read, and to RELEASE when it ends on any other operation.
- GAP goes to RSP after 2·HALF_DIV cycles.
- RSP goes to RELEASE when its frame ends.
- RELEASE goes to IDLE after one cycle.

Top module: `amp_mux_spi_host`

## Requirements
- R1: After reset the block is in IDLE with req_ready=1, busy=0, cs_n=1, bus_req=0, drv_en=0, sclk=0 and rd_valid=0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. From the next cycle, busy=1 and req_ready=0. Requests presented while busy are dropped and cause no bus traffic. busy falls one cycle after bus_req falls.
- R3: bus_req rises after a request is accepted. cs_n goes low only while bus_gnt is 1. From the grant to the first cs_n low there are at least 2·HALF_DIV cycles, during which drv_en=1, sclk=0 and cs_n=1. bus_req falls only when cs_n is already high.
- R4: Each frame is MSB first in mode 0. sclk idles low. mosi is stable while sclk is high. The reply bit on miso is sampled on each rising edge. A frame is 16 sclk pulses, or 32 when CHAIN=1.
- R5: Operation code 0 (select) sends the word 0x2A00 | (gain << 4) | channel, with gain and channel 4 bits each.
- R6: Code 2 (no-op) sends 0x0000. Code 3 (power down) sends 0xE1F1. Code 4 (wake) sends 0xE100. Codes 5 to 7 are sent as the no-op word. Each of these uses a single chip-select window.
- R7: Code 1 (read) sends 0x6A00 in one window. cs_n then stays high for at least 2·HALF_DIV cycles. A second window follows, in which mosi is all ones.
- R8: At the end of a read, rd_valid pulses for exactly one cycle. rd_data then holds the reply: in single mode the 16 reply bits zero-extended, first bit received as bit 15. rd_data keeps its value until the next read finishes.
- R9: With CHAIN=1, every command window carries 32 bits: the 16-bit word, then the same word OR 0x8000.
- R10: With CHAIN=1, a read returns 32 bits, with the first 16 bits received in rd_data[31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 3 | Operation code (0 select, 1 read, 2 no-op, 3 power down, 4 wake) |
| req_chan | input | 4 | Multiplexer channel for select |
| req_gain | input | 4 | Gain code for select |
| busy | output | 1 | Request in progress |
| bus_req | output | 1 | Bus lock request to the arbiter |
| bus_gnt | input | 1 | Bus lock grant |
| drv_en | output | 1 | Block is driving sclk, mosi and cs_n on the shared bus |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| rd_valid | output | 1 | One-cycle pulse when read data is ready |
| rd_data | output | 32 | Last read reply |

## Verification
A state register stuck in, or skipping, SETUP or GAP shows up at once as a chip-select low edge that comes too soon after the grant or after the previous window. A bad transition out of CMD shows up as a missing second window on a read, or an extra window on other operations. A shift counter or shift register that goes wrong changes the frame length or the captured word within the same frame. A wrong word mux is visible in the very first captured frame. A lost bus handshake shows as chip select low without a grant, or as the lock still held once the request is no longer busy.

// File: rtl/amp_spi_pkg.sv
package amp_spi_pkg;

    localparam logic [2:0] OP_SELECT = 3'd0;
    localparam logic [2:0] OP_READ   = 3'd1;
    localparam logic [2:0] OP_NOOP   = 3'd2;
    localparam logic [2:0] OP_SLEEP  = 3'd3;
    localparam logic [2:0] OP_WAKE   = 3'd4;

    localparam logic [15:0] W_SELECT   = 16'h2A00;
    localparam logic [15:0] W_READ     = 16'h6A00;
    localparam logic [15:0] W_NOOP     = 16'h0000;
    localparam logic [15:0] W_SLEEP    = 16'hE1F1;
    localparam logic [15:0] W_WAKE     = 16'hE100;
    localparam logic [15:0] CHAIN_MARK = 16'h8000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQUIRE,
        ST_SETUP,
        ST_CMD,
        ST_GAP,
        ST_RSP,
        ST_RELEASE
    } seq_state_e;

endpackage

// File: rtl/amp_spi_frame_enc.sv
module amp_spi_frame_enc
    import amp_spi_pkg::*;
#(
    parameter bit CHAIN = 1'b0,
    localparam int FB = CHAIN ? 32 : 16
) (
    input  logic [2:0]    op,
    input  logic [3:0]    chan,
    input  logic [3:0]    gain,
    output logic [FB-1:0] cmd_frame,
    output logic [FB-1:0] rsp_frame,
    output logic          is_read
);

    logic [15:0] word;

    always_comb begin
        unique case (op)
            OP_SELECT: word = W_SELECT | {8'h00, gain, chan};
            OP_READ:   word = W_READ;
            OP_SLEEP:  word = W_SLEEP;
            OP_WAKE:   word = W_WAKE;
            default:   word = W_NOOP;
        endcase
    end

    assign is_read   = (op == OP_READ);
    assign rsp_frame = '1;

    generate
        if (CHAIN) begin : g_chain
            assign cmd_frame = {word, word | CHAIN_MARK};
        end else begin : g_single
            assign cmd_frame = word;
        end
    endgenerate

endmodule

// File: rtl/amp_spi_shifter.sv
module amp_spi_shifter #(
    parameter int HALF_DIV   = 50,
    parameter int FRAME_BITS = 16,
    localparam int DW = $clog2(HALF_DIV + 1),
    localparam int CW = $clog2(FRAME_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] tx,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  done,
    output logic [FRAME_BITS-1:0] rx
);

    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(FRAME_BITS - 1);

    logic                  active_q, sclk_q, done_q;
    logic [DW-1:0]         div_q;
    logic [CW-1:0]         bits_q;
    logic [FRAME_BITS-1:0] tx_q, rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            done_q   <= 1'b0;
            div_q    <= '0;
            bits_q   <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                active_q <= 1'b1;
                sclk_q   <= 1'b0;
                div_q    <= '0;
                bits_q   <= '0;
                tx_q     <= tx;
                rx_q     <= '0;
            end else if (active_q) begin
                if (div_q == DIV_LAST) begin
                    div_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_q   <= {rx_q[FRAME_BITS-2:0], miso};
                    end else begin
                        sclk_q <= 1'b0;
                        tx_q   <= {tx_q[FRAME_BITS-2:0], 1'b0};
                        if (bits_q == BIT_LAST) begin
                            active_q <= 1'b0;
                            done_q   <= 1'b1;
                        end else begin
                            bits_q <= bits_q + 1'b1;
                        end
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    assign sclk = sclk_q;
    assign mosi = tx_q[FRAME_BITS-1];
    assign done = done_q;
    assign rx   = rx_q;

    // R4
    sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> !sclk_q);

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && sclk_q) |-> $stable(tx_q));

endmodule

// File: rtl/amp_spi_seq_fsm.sv
module amp_spi_seq_fsm
    import amp_spi_pkg::*;
#(
    parameter int HALF_DIV   = 50,
    parameter int FRAME_BITS = 16,
    localparam int SETUP_CYC = 2 * HALF_DIV,
    localparam int TW        = $clog2(SETUP_CYC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  is_read,
    input  logic                  bus_gnt,
    input  logic                  shift_done,
    input  logic [FRAME_BITS-1:0] rx,
    output logic                  req_ready,
    output logic                  busy,
    output logic                  bus_req,
    output logic                  drv_en,
    output logic                  cs_n,
    output logic                  sh_start,
    output logic                  sel_rsp,
    output logic                  rd_valid,
    output logic [31:0]           rd_data
);

    localparam logic [TW-1:0] SETUP_LAST = TW'(SETUP_CYC - 1);

    seq_state_e    state_q, state_d;
    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= (state_d != state_q) ? '0 : tmr_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_ACQUIRE;
            ST_ACQUIRE: if (bus_gnt) state_d = ST_SETUP;
            ST_SETUP:   if (tmr_q == SETUP_LAST) state_d = ST_CMD;
            ST_CMD:     if (shift_done) state_d = is_read ? ST_GAP : ST_RELEASE;
            ST_GAP:     if (tmr_q == SETUP_LAST) state_d = ST_RSP;
            ST_RSP:     if (shift_done) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        busy      = (state_q != ST_IDLE);
        bus_req   = state_q inside {ST_ACQUIRE, ST_SETUP, ST_CMD, ST_GAP, ST_RSP};
        drv_en    = state_q inside {ST_SETUP, ST_CMD, ST_GAP, ST_RSP};
        cs_n      = !(state_q inside {ST_CMD, ST_RSP});
        sel_rsp   = (state_d == ST_RSP);
        sh_start  = ((state_d == ST_CMD) && (state_q != ST_CMD)) ||
                    ((state_d == ST_RSP) && (state_q != ST_RSP));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state_q == ST_RSP) && shift_done;
            if ((state_q == ST_RSP) && shift_done) rd_data <= 32'(rx);
        end
    end

    // R3
    cs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> bus_gnt);

    // R3
    drop_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> (cs_n && !drv_en));

    // R2
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R8
    rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/amp_mux_spi_host.sv
module amp_mux_spi_host #(
    parameter bit CHAIN    = 1'b0,
    parameter int HALF_DIV = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [2:0]  req_op,
    input  logic [3:0]  req_chan,
    input  logic [3:0]  req_gain,
    output logic        busy,
    output logic        bus_req,
    input  logic        bus_gnt,
    output logic        drv_en,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso,
    output logic        rd_valid,
    output logic [31:0] rd_data
);

    localparam int FB = CHAIN ? 32 : 16;

    logic [2:0]    op_q;
    logic [3:0]    chan_q, gain_q;
    logic [FB-1:0] cmd_frame, rsp_frame, rx;
    logic          is_read, sh_start, sel_rsp, sh_done, sh_sclk, sh_mosi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            chan_q <= '0;
            gain_q <= '0;
        end else if (req_valid && req_ready) begin
            op_q   <= req_op;
            chan_q <= req_chan;
            gain_q <= req_gain;
        end
    end

    amp_spi_frame_enc #(.CHAIN(CHAIN)) u_enc (
        .op        (op_q),
        .chan      (chan_q),
        .gain      (gain_q),
        .cmd_frame (cmd_frame),
        .rsp_frame (rsp_frame),
        .is_read   (is_read)
    );

    amp_spi_seq_fsm #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FB)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .is_read    (is_read),
        .bus_gnt    (bus_gnt),
        .shift_done (sh_done),
        .rx         (rx),
        .req_ready  (req_ready),
        .busy       (busy),
        .bus_req    (bus_req),
        .drv_en     (drv_en),
        .cs_n       (cs_n),
        .sh_start   (sh_start),
        .sel_rsp    (sel_rsp),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    amp_spi_shifter #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FB)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sh_start),
        .tx    (sel_rsp ? rsp_frame : cmd_frame),
        .miso  (miso),
        .sclk  (sh_sclk),
        .mosi  (sh_mosi),
        .done  (sh_done),
        .rx    (rx)
    );

    assign sclk = sh_sclk & drv_en;
    assign mosi = sh_mosi & ~cs_n;

endmodule

// File: tb/amp_mux_spi_host_tb.sv
module amp_spi_peer_model (
    input  logic        clk,
    input  logic        clr,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi,
    input  logic        bus_req,
    input  logic        rdv,
    input  logic [31:0] rdd,
    input  logic [31:0] resp,
    input  logic [7:0]  dly,
    output logic        miso,
    output logic        gnt
);
    logic [31:0] fr_val [0:3];
    int          fr_len [0:3];
    int          fr_cnt = 0, len = 0, gap_min = 999, hi_cnt = 0;
    int          setup_cnt = 0, setup_seen = 0, viol = 0, dcnt = 0, rdv_cnt = 0;
    logic [31:0] sh = 0, rsp_sh = 0, rd_seen = 0;
    logic        prev_cs = 1'b1, prev_sclk = 1'b0;

    initial begin
        miso = 1'b0;
        gnt  = 1'b0;
    end

    always @(negedge clk) begin
        if (clr) begin
            fr_cnt = 0; gap_min = 999; hi_cnt = 0; setup_cnt = 0;
            setup_seen = 0; viol = 0; rdv_cnt = 0;
        end else begin
            if (!bus_req) begin gnt = 1'b0; dcnt = 0; setup_cnt = 0; end
            else if (dcnt >= int'(dly)) gnt = 1'b1;
            else dcnt++;
            if (gnt && cs_n) setup_cnt++;
            if (!cs_n && !gnt) viol++;
            if (rdv) begin rdv_cnt++; rd_seen = rdd; end
            if (prev_cs && !cs_n) begin
                sh = 0; len = 0; rsp_sh = resp; miso = resp[31];
                if (fr_cnt == 0) setup_seen = setup_cnt;
                else if (hi_cnt < gap_min) gap_min = hi_cnt;
            end else if (!cs_n && !prev_sclk && sclk) begin
                sh = {sh[30:0], mosi}; len++;
            end else if (!cs_n && prev_sclk && !sclk) begin
                rsp_sh = {rsp_sh[30:0], 1'b1}; miso = rsp_sh[31];
            end
            if (!prev_cs && cs_n) begin
                if (fr_cnt < 4) begin fr_val[fr_cnt] = sh; fr_len[fr_cnt] = len; end
                fr_cnt++; hi_cnt = 1;
            end else if (cs_n) hi_cnt++;
        end
        prev_cs = cs_n; prev_sclk = sclk;
    end
endmodule

module amp_mux_spi_host_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HD = 2;

    logic        clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
    logic        v_a = 1'b0, v_b = 1'b0;
    logic [2:0]  op = '0;
    logic [3:0]  ch = '0, gn = '0;
    logic [31:0] resp = '0;
    logic [7:0]  dly = '0;
    int          total = 0, bad = 0;

    logic rdy_a, busy_a, req_a, gnt_a, drv_a, sclk_a, cs_a, mosi_a, miso_a, rdv_a;
    logic rdy_b, busy_b, req_b, gnt_b, drv_b, sclk_b, cs_b, mosi_b, miso_b, rdv_b;
    logic [31:0] rdd_a, rdd_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    amp_mux_spi_host #(.CHAIN(1'b0), .HALF_DIV(HD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(v_a), .req_ready(rdy_a),
        .req_op(op), .req_chan(ch), .req_gain(gn), .busy(busy_a),
        .bus_req(req_a), .bus_gnt(gnt_a), .drv_en(drv_a), .sclk(sclk_a),
        .cs_n(cs_a), .mosi(mosi_a), .miso(miso_a), .rd_valid(rdv_a), .rd_data(rdd_a));

    amp_mux_spi_host #(.CHAIN(1'b1), .HALF_DIV(HD)) u_dut_chain (
        .clk(clk), .rst_n(rst_n), .req_valid(v_b), .req_ready(rdy_b),
        .req_op(op), .req_chan(ch), .req_gain(gn), .busy(busy_b),
        .bus_req(req_b), .bus_gnt(gnt_b), .drv_en(drv_b), .sclk(sclk_b),
        .cs_n(cs_b), .mosi(mosi_b), .miso(miso_b), .rd_valid(rdv_b), .rd_data(rdd_b));

    amp_spi_peer_model m_a (.clk(clk), .clr(clr), .sclk(sclk_a), .cs_n(cs_a),
        .mosi(mosi_a), .bus_req(req_a), .rdv(rdv_a), .rdd(rdd_a), .resp(resp),
        .dly(dly), .miso(miso_a), .gnt(gnt_a));
    amp_spi_peer_model m_b (.clk(clk), .clr(clr), .sclk(sclk_b), .cs_n(cs_b),
        .mosi(mosi_b), .bus_req(req_b), .rdv(rdv_b), .rdd(rdd_b), .resp(resp),
        .dly(dly), .miso(miso_b), .gnt(gnt_b));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [2:0] o, input logic [3:0] c,
                                             input logic [3:0] g);
        case (o)
            3'd0:    return 16'h2A00 | {8'h00, g, c};
            3'd1:    return 16'h6A00;
            3'd3:    return 16'hE1F1;
            3'd4:    return 16'hE100;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic run_txn(input bit chain, input logic [2:0] o, input logic [3:0] c,
                           input logic [3:0] g, input logic [31:0] r, input logic [7:0] d);
        logic [31:0] prev_rd, w, exp_cmd, got;
        int          fb, n;
        string       tag;
        fb = chain ? 32 : 16;
        w = 32'(exp_word(o, c, g));
        exp_cmd = chain ? {w[15:0], w[15:0] | 16'h8000} : w;
        tag = chain ? "R9" : (o == 3'd0 ? "R5" : (o == 3'd1 ? "R7" : "R6"));
        @(posedge clk); #1; clr = 1'b1; resp = r; dly = d;
        @(posedge clk); #1; clr = 1'b0;
        prev_rd = chain ? rdd_b : rdd_a;
        chk(chain ? rdy_b : rdy_a, "R2 ready when idle", 0, 1);
        op = o; ch = c; gn = g;
        if (chain) v_b = 1'b1; else v_a = 1'b1;
        @(posedge clk); #1; v_a = 1'b0; v_b = 1'b0;
        chk((chain ? busy_b : busy_a) && !(chain ? rdy_b : rdy_a), "R2 busy after accept", 0, 1);
        // R2: request offered while busy must be dropped
        op = 3'd3; ch = 4'hA; gn = 4'h5;
        if (chain) v_b = 1'b1; else v_a = 1'b1;
        repeat (3) @(posedge clk);
        #1; v_a = 1'b0; v_b = 1'b0;
        n = 0;
        while ((chain ? busy_b : busy_a) && n < 5000) begin @(posedge clk); #1; n++; end
        repeat (2) @(posedge clk);
        #1;
        chk(n < 5000, "R2 busy ends", n, 0);
        chk(!(chain ? req_b : req_a) && (chain ? cs_b : cs_a), "R3 bus released", 0, 0);
        chk((chain ? m_b.viol : m_a.viol) == 0, "R3 cs low without grant",
            chain ? m_b.viol : m_a.viol, 0);
        chk((chain ? m_b.setup_seen : m_a.setup_seen) >= 2*HD, "R3 setup after grant",
            chain ? m_b.setup_seen : m_a.setup_seen, 2*HD);
        chk((chain ? m_b.fr_len[0] : m_a.fr_len[0]) == fb, "R4 frame length",
            chain ? m_b.fr_len[0] : m_a.fr_len[0], fb);
        got = chain ? m_b.fr_val[0] : m_a.fr_val[0];
        if (!chain) got = {16'h0, got[15:0]};
        if (o != 3'd1) begin
            chk((chain ? m_b.fr_cnt : m_a.fr_cnt) == 1, {tag, " window count"},
                chain ? m_b.fr_cnt : m_a.fr_cnt, 1);
            chk(got == exp_cmd, {tag, " command word"}, got, exp_cmd);
            chk((chain ? m_b.rdv_cnt : m_a.rdv_cnt) == 0 &&
                (chain ? rdd_b : rdd_a) == prev_rd, "R8 rd_data held",
                chain ? rdd_b : rdd_a, prev_rd);
        end else begin
            chk((chain ? m_b.fr_cnt : m_a.fr_cnt) == 2, "R7 two windows",
                chain ? m_b.fr_cnt : m_a.fr_cnt, 2);
            chk(got == exp_cmd, {tag, " read command"}, got, exp_cmd);
            got = chain ? m_b.fr_val[1] : m_a.fr_val[1];
            if (!chain) got = {16'h0, got[15:0]};
            chk(got == (chain ? 32'hFFFF_FFFF : 32'h0000_FFFF), "R7 filler ones",
                got, chain ? 32'hFFFF_FFFF : 32'h0000_FFFF);
            chk((chain ? m_b.gap_min : m_a.gap_min) >= 2*HD, "R7 cs high gap",
                chain ? m_b.gap_min : m_a.gap_min, 2*HD);
            w = chain ? r : {16'h0, r[31:16]};
            chk((chain ? m_b.rdv_cnt : m_a.rdv_cnt) == 1, "R8 one rd_valid pulse",
                chain ? m_b.rdv_cnt : m_a.rdv_cnt, 1);
            chk((chain ? m_b.rd_seen : m_a.rd_seen) == w, chain ? "R10 chain reply" : "R8 reply",
                chain ? m_b.rd_seen : m_a.rd_seen, w);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        bad++; total++;
        $display("FAIL watchdog R2 act=%h exp=%h", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7421));
        repeat (4) @(posedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rdy_a && !busy_a && cs_a && !req_a && !drv_a && !sclk_a && !rdv_a,
            "R1 reset single", 0, 1);
        chk(rdy_b && !busy_b && cs_b && !req_b && !drv_b && !sclk_b && !rdv_b,
            "R1 reset chain", 0, 1);
        for (int k = 0; k < 2; k++) begin
            run_txn(k == 1, 3'd0, 4'hF, 4'hF, 32'h0, 8'd3);
            run_txn(k == 1, 3'd0, 4'h0, 4'h0, 32'h0, 8'd0);
            run_txn(k == 1, 3'd1, 4'h0, 4'h0, 32'hFFFF_FFFF, 8'd0);
            run_txn(k == 1, 3'd1, 4'h0, 4'h0, 32'h0000_0000, 8'd9);
            run_txn(k == 1, 3'd1, 4'h0, 4'h0, 32'hA55A_3CC3, 8'd1);
            for (int o = 2; o < 8; o++) run_txn(k == 1, 3'(o), 4'h3, 4'h9, 32'h1234_5678, 8'd2);
        end
        for (int i = 0; i < 60; i++) begin
            run_txn(i[0], 3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)),
                    4'($urandom_range(0, 15)), $urandom, 8'($urandom_range(0, 20)));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule